// File: doc/BRIEF.md
# Cache Block Refill Controller with Interleaved Banks

This block sits on the memory side of a cache and answers block refill requests over a bus that is one word wide. A refill asks for a four-word block by its block address. The controller spends one bus cycle taking the address and then waits for the DRAM access time. It then sends the four words back in order, each with a valid strobe and its word offset. When the last word has gone out, it raises a done pulse and reports the total refill time in cycles.

The storage is split into four banks. Each bank holds the words whose word address has the given value in its two low bits. A mode input picks how the banks are used. In sequential mode they behave like one memory one word wide, so every word costs a full access followed by its transfer. In interleaved mode all four banks are read at once after a single access, and the words are then streamed one per cycle. The mode is sampled when a request is accepted. A simple write port fills the banks, which lets the contents be preset before refills are issued.

Top module: `blk_fetch_ctl`

## Requirements
- R1: After reset, and after a reset applied in the middle of a refill, req_ready is 1, word_valid is 0, done is 0 and penalty is 0.
- R2: A request is taken only when req_valid and req_ready are both 1. req_ready is 0 from the cycle after acceptance until the done cycle. A request raised during a refill is ignored, and no new refill starts from it.
- R3: The words come out with word_idx 0, 1, 2, 3 in that order. Each word equals the memory word at word address {block, word_idx}.
- R4: A write with wr_en stores wr_data at word address wr_addr. Bits [1:0] of wr_addr select the bank, and the upper bits select the row. A later refill of that block returns the new word and leaves the other three words unchanged.
- R5: With fetch_ilv=0 at acceptance (sequential mode), counting the cycle after the accepting edge as cycle 0, word k is valid in cycle 16+16k and done is in cycle 65.
- R6: With fetch_ilv=1 at acceptance (interleaved mode), word k is valid in cycle 16+k and done is in cycle 20.
- R7: penalty takes the refill length on done (65 in sequential mode, 20 in interleaved mode). It keeps that value until the next refill completes.
- R8: Changing fetch_ilv during a refill has no effect on that refill's timing or penalty.
- R9: done is a single-cycle pulse in the cycle right after the last word. req_ready is 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_ilv | input | 1 | 1 = interleaved banks, 0 = sequential word-wide access |
| req_valid | input | 1 | Refill request |
| req_blk | input | BLK_AW (6) | Block address of the request |
| req_ready | output | 1 | Controller idle and able to accept |
| wr_en | input | 1 | Preset write enable |
| wr_addr | input | BLK_AW+2 (8) | Word address of the preset write |
| wr_data | input | DW (32) | Preset write data |
| word_valid | output | 1 | A returned word is on word_data |
| word_idx | output | 2 | Word offset of the returned word |
| word_data | output | DW (32) | Returned word |
| done | output | 1 | Refill finished pulse |
| penalty | output | PW (8) | Cycle count of the last completed refill |

## Verification
The properties assume two things: a new request is only looked at while req_ready is high, and the timing parameters keep their defaults, so the only legal refill lengths are 65 and 20. The properties also assume the preset write port is not used during a refill. The stimulus drives every input at the falling clock edge. It writes memory only while the controller is idle, and it drops any request raised during a refill before the done cycle. This means the only acceptances are the intended ones. Mode flips and stray requests during a refill are injected on purpose, to show they are ignored.

// File: rtl/fill_pkg.sv
package fill_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_ACC  = 2'd2,
    ST_XFER = 2'd3
  } fill_state_e;
endpackage

// File: rtl/fill_bank.sv
module fill_bank #(
  parameter int DW = 32,
  parameter int RW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          re,
  input  logic [RW-1:0] ra,
  output logic [DW-1:0] q
);
  localparam int ROWS = 1 << RW;
  logic [DW-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) q <= mem[ra];
  end
endmodule

// File: rtl/fill_seq.sv
module fill_seq
  import fill_pkg::*;
#(
  parameter int NW       = 4,
  parameter int ADDR_CYC = 1,
  parameter int ACC_CYC  = 15,
  localparam int OW = $clog2(NW),
  localparam int TMAX = (ADDR_CYC > ACC_CYC) ? ADDR_CYC : ACC_CYC,
  localparam int TW = $clog2(TMAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          mode_in,
  output logic          ready,
  output logic          accept,
  output logic          xfer,
  output logic          last_xfer,
  output logic [NW-1:0] rd_en,
  output logic [OW-1:0] idx,
  output logic          done
);
  fill_state_e   state;
  logic [TW-1:0] tmr;
  logic          mode_q;

  assign ready     = (state == ST_IDLE);
  assign accept    = ready && req_valid;
  assign xfer      = (state == ST_XFER);
  assign last_xfer = xfer && (idx == OW'(NW - 1));

  always_comb begin
    rd_en = '0;
    if (state == ST_ACC && tmr == TW'(ACC_CYC - 1)) begin
      if (mode_q) rd_en = '1;
      else        rd_en[idx] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      tmr    <= '0;
      idx    <= '0;
      mode_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          state  <= ST_ADDR;
          tmr    <= '0;
          idx    <= '0;
          mode_q <= mode_in;
        end
        ST_ADDR: begin
          if (tmr == TW'(ADDR_CYC - 1)) begin
            state <= ST_ACC;
            tmr   <= '0;
          end else tmr <= tmr + 1'b1;
        end
        ST_ACC: begin
          if (tmr == TW'(ACC_CYC - 1)) begin
            state <= ST_XFER;
            tmr   <= '0;
          end else tmr <= tmr + 1'b1;
        end
        ST_XFER: begin
          if (idx == OW'(NW - 1)) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
            if (!mode_q) state <= ST_ACC;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fill_pen.sv
module fill_pen #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          busy,
  input  logic          last,
  output logic [PW-1:0] penalty
);
  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      penalty <= '0;
    end else begin
      if (start)     cnt <= '0;
      else if (busy) cnt <= cnt + 1'b1;
      if (last) penalty <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/blk_fetch_ctl.sv
module blk_fetch_ctl #(
  parameter int DW       = 32,
  parameter int BLK_AW   = 6,
  parameter int ADDR_CYC = 1,
  parameter int ACC_CYC  = 15,
  parameter int PW       = 8,
  localparam int NW = 4,
  localparam int OW = $clog2(NW),
  localparam int WAW = BLK_AW + OW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_ilv,
  input  logic              req_valid,
  input  logic [BLK_AW-1:0] req_blk,
  output logic              req_ready,
  input  logic              wr_en,
  input  logic [WAW-1:0]    wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic              word_valid,
  output logic [OW-1:0]     word_idx,
  output logic [DW-1:0]     word_data,
  output logic              done,
  output logic [PW-1:0]     penalty
);
  logic              accept, xfer, last_xfer;
  logic [NW-1:0]     rd_en;
  logic [BLK_AW-1:0] blk_q;
  logic [DW-1:0]     bank_q [NW];

  always_ff @(posedge clk) begin
    if (rst)         blk_q <= '0;
    else if (accept) blk_q <= req_blk;
  end

  fill_seq #(.NW(NW), .ADDR_CYC(ADDR_CYC), .ACC_CYC(ACC_CYC)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .mode_in(fetch_ilv),
    .ready(req_ready), .accept(accept), .xfer(xfer), .last_xfer(last_xfer),
    .rd_en(rd_en), .idx(word_idx), .done(done)
  );

  for (genvar b = 0; b < NW; b++) begin : g_bank
    fill_bank #(.DW(DW), .RW(BLK_AW)) u_bank (
      .clk(clk),
      .we(wr_en && (wr_addr[OW-1:0] == OW'(b))),
      .wa(wr_addr[WAW-1:OW]),
      .wd(wr_data),
      .re(rd_en[b]),
      .ra(blk_q),
      .q(bank_q[b])
    );
  end

  fill_pen #(.PW(PW)) u_pen (
    .clk(clk), .rst(rst), .start(accept), .busy(!req_ready),
    .last(last_xfer), .penalty(penalty)
  );

  assign word_valid = xfer;
  assign word_data  = bank_q[word_idx];
endmodule

// File: rtl/fill_chk.sv
module fill_chk #(
  parameter int NW      = 4,
  parameter int PW      = 8,
  parameter int SEQ_PEN = 65,
  parameter int ILV_PEN = 20,
  localparam int OW = $clog2(NW)
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          word_valid,
  input logic [OW-1:0] word_idx,
  input logic          done,
  input logic [PW-1:0] penalty
);
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_no_word_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> !req_ready);

  assert_word_order_R3: assert property (@(posedge clk) disable iff (rst)
    (word_valid && $past(word_valid)) |-> (word_idx == OW'($past(word_idx) + 1'b1)));

  assert_done_follows_last_R9: assert property (@(posedge clk) disable iff (rst)
    (word_valid && word_idx == OW'(NW - 1)) |=> (done && req_ready));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_penalty_legal_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (penalty == PW'(SEQ_PEN) || penalty == PW'(ILV_PEN)));

  assert_penalty_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(penalty) |-> done);
endmodule

bind blk_fetch_ctl fill_chk #(
  .NW(NW), .PW(PW),
  .SEQ_PEN(ADDR_CYC + NW * (ACC_CYC + 1)),
  .ILV_PEN(ADDR_CYC + ACC_CYC + NW)
) u_fill_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .word_valid(word_valid), .word_idx(word_idx), .done(done), .penalty(penalty)
);

// File: tb/test_blk_fetch_ctl.sv
module test_blk_fetch_ctl;
  localparam int NBLK = 64;
  localparam int NWRD = NBLK * 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_ilv = 1'b0;
  logic        req_valid = 1'b0;
  logic [5:0]  req_blk = '0;
  logic        req_ready;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        word_valid;
  logic [1:0]  word_idx;
  logic [31:0] word_data;
  logic        done;
  logic [7:0]  penalty;

  int tests = 0;
  int fails = 0;
  int prev_pen = 0;
  bit finished = 1'b0;
  logic [31:0] exp_mem [NWRD];

  always #2.5 clk = ~clk;

  blk_fetch_ctl i_blk_fetch_ctl (
    .clk(clk), .rst(rst), .fetch_ilv(fetch_ilv), .req_valid(req_valid),
    .req_blk(req_blk), .req_ready(req_ready), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .word_valid(word_valid), .word_idx(word_idx),
    .word_data(word_data), .done(done), .penalty(penalty)
  );

  localparam int NVEC = 6;
  localparam int V_MODE [NVEC] = '{0, 1, 1, 0, 1, 0};
  localparam int V_BLK  [NVEC] = '{5, 5, 0, 63, 42, 17};
  localparam int V_PEN  [NVEC] = '{65, 20, 20, 65, 20, 65};

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic mem_write(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'(a); wr_data = d;
    exp_mem[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // One refill; disturb injects a mode flip and a stray request mid-refill (R2, R8)
  task automatic refill(input int mode, input int blk, input bit disturb);
    int pen = (mode != 0) ? 20 : 65;
    int nword = 0;
    @(negedge clk);
    fetch_ilv = mode[0]; req_blk = 6'(blk); req_valid = 1'b1;
    @(posedge clk);
    for (int cyc = 0; cyc <= pen; cyc++) begin
      bit ev;
      int k;
      @(negedge clk);
      if (cyc == 0) req_valid = 1'b0;
      if (disturb && cyc == 3) begin
        fetch_ilv = ~mode[0]; req_valid = 1'b1; req_blk = 6'(blk ^ 1);
      end
      if (disturb && cyc == pen - 1) req_valid = 1'b0;
      if (mode != 0) begin ev = (cyc >= 16 && cyc <= 19); k = cyc - 16; end
      else begin ev = (cyc >= 16 && ((cyc - 16) % 16) == 0 && cyc <= 64); k = (cyc - 16) / 16; end
      check(word_valid == ev, mode != 0 ? "R6 word timing" : "R5 word timing", word_valid, ev);
      if (ev && word_valid) begin
        check(word_idx == 2'(k), "R3 word order", word_idx, k);
        check(word_data == exp_mem[blk * 4 + k], "R3 word data", word_data, exp_mem[blk * 4 + k]);
        nword++;
      end
      check(req_ready == (cyc == pen), "R2 ready during refill", req_ready, cyc == pen);
      check(done == (cyc == pen), "R9 done timing", done, cyc == pen);
      if (cyc < pen) check(penalty == 8'(prev_pen), "R7 penalty held", penalty, prev_pen);
      else begin
        check(penalty == 8'(pen), disturb ? "R8 penalty after mode flip" : "R7 penalty value",
              penalty, pen);
      end
    end
    check(nword == 4, "R3 word count", nword, 4);
    prev_pen = pen;
    @(negedge clk);
    check(req_ready && !word_valid && !done, "R2 no stray refill", {req_ready, word_valid, done}, 3'b100);
  endtask

  initial begin
    for (int a = 0; a < NWRD; a++) exp_mem[a] = 32'h5A00_0000 ^ (32'(a) * 32'h0001_0203);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready && !word_valid && !done && penalty == 0, "R1 reset state",
          {req_ready, word_valid, done, penalty}, 11'h400);
    for (int a = 0; a < NWRD; a++) begin
      wr_en = 1'b1; wr_addr = 8'(a); wr_data = exp_mem[a];
      @(negedge clk);
    end
    wr_en = 1'b0;

    for (int v = 0; v < NVEC; v++) refill(V_MODE[v], V_BLK[v], 1'b0);

    // R8 and R2: mode flip and stray request while busy, both modes
    refill(0, 9, 1'b1);
    refill(1, 33, 1'b1);

    // R4: one word rewritten, bank 2 of block 9
    mem_write(9 * 4 + 2, 32'hDEAD_BEEF);
    refill(1, 9, 1'b0);
    mem_write(20 * 4 + 3, 32'h0BAD_F00D);
    refill(0, 20, 1'b0);

    // R1: reset in the middle of a refill
    @(negedge clk);
    fetch_ilv = 1'b0; req_blk = 6'd4; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready && !word_valid && !done && penalty == 0, "R1 reset mid refill",
          {req_ready, word_valid, done, penalty}, 11'h400);
    prev_pen = 0;
    refill(1, 4, 1'b0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule